// File: doc/BRIEF.md
# Variable-Length SPI Burst Engine

This block moves one SPI burst of any length from 1 to 4096 bits. The burst data passes through a 32-bit-wide transmit FIFO and a 32-bit-wide receive FIFO. It runs in one of two roles. As master, it produces the serial clock from a fixed divider and holds chip select low for the whole burst. As slave, it follows an external clock and select, which it first passes through synchronizers.

Outgoing data is framed so that the first FIFO word holds the bits left over when the length is not a multiple of 32. Incoming data is packed 32 bits at a time from the start of the burst, and any leftover bits go into a final word aligned to the right. In the slave role, a control input picks how the burst ends: after the programmed bit count, or when the select line goes inactive.

The clock format is fixed: the clock idles low, data changes while the clock is low, and each bit is sampled on the rising clock edge. Software fills the transmit FIFO, sets the length and the role, and starts the burst (master) or waits for select (slave). It then drains the receive FIFO when `done` pulses.

Top module: `spi_burst_engine`

## Requirements
- R1: `cfg_len` holds the bit count minus one. A master burst produces exactly `cfg_len`+1 rising edges on `spi_sclk_o`. The clock rises only while a burst is running in the master role.
- R2: The first transmit word supplies only its lowest ((`cfg_len`+1) mod 32) bits, or all 32 bits when that value is 0. Each later word supplies all 32 bits. Bits go out most significant first, and no word is sent twice. For `cfg_len`=32 with words 0x00000001 and 0xAAAAAAAA, the line carries a single 1 followed by 0xAAAAAAAA.
- R3: In the master role, `spi_cs_n_o` goes low once per burst and stays low until the burst completes. When idle, `spi_cs_n_o` is 1 and `spi_sclk_o` is 0.
- R4: If the transmit FIFO is empty when the master needs a new word, the clock stops low with select still low. The burst resumes once a word is written.
- R5: Received bits are packed MSB first into 32-bit words counted from the start of the burst. A final partial word is pushed into the receive FIFO right-aligned and zero-extended when the burst ends.
- R6: In the slave role with `cfg_ss_end`=0, the burst ends after `cfg_len`+1 received bits. Further clock edges before select goes high and low again are ignored.
- R7: In the slave role with `cfg_ss_end`=1, the burst ends when the synchronized `spi_cs_n_i` rises, whatever the value of `cfg_len`.
- R8: `done` is a one-cycle pulse, exactly once per burst, and `busy` is high from burst start until that pulse.
- R9: In the slave role, `spi_dout` carries transmit data framed as in R2. It carries zeros once the transmit FIFO has run out.
- R10: After reset, `spi_cs_n_o`=1, `spi_sclk_o`=0, `done`=0 and `busy`=0. The receive FIFO is empty and the transmit FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_len | input | LEN_W | Burst bit count minus one |
| cfg_ss_end | input | 1 | Slave: 1 = end the burst on select release, 0 = end it on the bit count |
| start | input | 1 | Master: begin a burst when idle |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_data | input | 32 | Transmit FIFO write word |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_data | output | 32 | Receive FIFO head word |
| rx_empty | output | 1 | Receive FIFO empty |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| spi_sclk_o | output | 1 | Master serial clock |
| spi_cs_n_o | output | 1 | Master chip select, active low |
| spi_sclk_i | input | 1 | Slave serial clock |
| spi_cs_n_i | input | 1 | Slave chip select, active low |
| spi_dout | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| spi_din | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The bench aims at the 32n+1 length. A design that mishandles it would repeat part of the first word or shift the whole stream by one bit. A 70-bit burst with a 6-bit leading word and a deliberately starved transmit FIFO checks that the master holds a low clock and an asserted select, rather than clocking out stale bits or releasing select. In the slave role, a count-terminated burst is followed by extra clock edges, which a wrong design would pack into a second word or answer with a second `done`. A select-terminated 40-bit burst with a short length field checks that the trailing 8 bits arrive right-aligned and that an empty transmit FIFO yields zeros on the output line.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
// Shared constants and the burst sequencer state type.
package spi_burst_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } burst_st_e;
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
// Synchronous first-word-fall-through FIFO.
// Assumes: a write while full and a read while empty are dropped.
module spi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_pack.sv
`timescale 1ns/1ps
// Packs received serial bits MSB first into words counted from the burst start.
// A flush with a partial word pending emits it right-aligned.
// Assumes: flush never arrives in the same cycle as a bit.
module spi_rx_pack #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_vld,
    input  logic         bit_in,
    input  logic         flush,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0] acc;
    logic [CW-1:0] cnt;

    // Shift in bits; emit a word on a full count or on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            cnt  <= '0;
            push <= 1'b0;
            word <= '0;
        end else begin
            push <= 1'b0;
            if (bit_vld) begin
                if (cnt == CW'(W-1)) begin
                    word <= {acc[W-2:0], bit_in};
                    push <= 1'b1;
                    acc  <= '0;
                    cnt  <= '0;
                end else begin
                    acc <= {acc[W-2:0], bit_in};
                    cnt <= cnt + 1'b1;
                end
            end else if (flush && cnt != '0) begin
                word <= acc;
                push <= 1'b1;
                acc  <= '0;
                cnt  <= '0;
            end
        end
    end
endmodule

// File: rtl/spi_burst_engine.sv
`timescale 1ns/1ps
// Variable-length SPI burst engine, master or slave, clock idle low, rising-edge sample.
// Transmit framing: the first word carries (len+1) mod 32 bits (32 if zero), MSB first.
// Assumes: configuration inputs are stable while busy; LEN_W >= 5.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 12,
    parameter int HALF_DIV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_ss_end,
    input  logic              start,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              busy,
    output logic              done,
    output logic              spi_sclk_o,
    output logic              spi_cs_n_o,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    output logic              spi_dout,
    input  logic              spi_din
);
    localparam int CNT_W = LEN_W + 1;
    localparam int DIV_W = $clog2(HALF_DIV + 1);

    burst_st_e          st;
    logic [WORD_W-1:0]  tx_word, tx_rdata, rx_word;
    logic [IDX_W-1:0]   bit_idx;
    logic [CNT_W-1:0]   bits_left;
    logic [DIV_W-1:0]   div_cnt;
    logic               sclk_q, cs_q;
    logic               tx_empty, tx_pop, rx_push;
    logic               bit_evt, bit_val, div_end, len_end;
    logic [2:0]         sclk_s, cs_s;
    logic [1:0]         din_s;
    logic               s_rise, cs_fall, cs_rise;

    spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .wr_en(tx_wr), .wr_data(tx_data), .full(tx_full),
        .rd_en(tx_pop), .rd_data(tx_rdata), .empty(tx_empty)
    );

    spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .wr_en(rx_push), .wr_data(rx_word), .full(),
        .rd_en(rx_rd), .rd_data(rx_data), .empty(rx_empty)
    );

    spi_rx_pack #(.W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_evt), .bit_in(bit_val),
        .flush(st == ST_DONE), .push(rx_push), .word(rx_word)
    );

    // Synchronize the slave-side pins and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            din_s  <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], spi_sclk_i};
            cs_s   <= {cs_s[1:0], spi_cs_n_i};
            din_s  <= {din_s[0], spi_din};
        end
    end

    assign s_rise  = sclk_s[1] & ~sclk_s[2];
    assign cs_fall = ~cs_s[1] & cs_s[2];
    assign cs_rise = cs_s[1] & ~cs_s[2];
    assign div_end = (div_cnt == DIV_W'(HALF_DIV - 1));
    assign len_end = !cfg_ss_end && (bits_left == '0);

    // Per-cycle bit event, sampled bit and transmit FIFO pop.
    always_comb begin
        bit_evt = 1'b0;
        bit_val = 1'b0;
        tx_pop  = 1'b0;
        case (st)
            ST_LOAD: tx_pop = !tx_empty;
            ST_LOW: begin
                if (cfg_master) begin
                    bit_evt = div_end;
                    bit_val = spi_din;
                end else begin
                    bit_evt = s_rise && !cs_rise && !len_end;
                    bit_val = din_s[1];
                    tx_pop  = bit_evt && (bit_idx == '0) && !tx_empty;
                end
            end
            default: ;
        endcase
    end

    // Burst sequencer: start, word load, clock halves, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            tx_word   <= '0;
            bit_idx   <= '0;
            bits_left <= '0;
            div_cnt   <= '0;
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if ((cfg_master && start) || (!cfg_master && cs_fall)) begin
                        bits_left <= CNT_W'(cfg_len) + 1'b1;
                        bit_idx   <= cfg_len[IDX_W-1:0];
                        cs_q      <= !cfg_master;
                        st        <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    div_cnt <= '0;
                    if (!tx_empty) begin
                        tx_word <= tx_rdata;
                        st      <= ST_LOW;
                    end else if (!cfg_master) begin
                        tx_word <= '0;
                        st      <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (cfg_master) begin
                        if (div_end) begin
                            div_cnt   <= '0;
                            sclk_q    <= 1'b1;
                            bits_left <= bits_left - 1'b1;
                            st        <= ST_HIGH;
                        end else begin
                            div_cnt <= div_cnt + 1'b1;
                        end
                    end else if (cs_rise || len_end) begin
                        st <= ST_DONE;
                    end else if (s_rise) begin
                        if (bits_left != '0) bits_left <= bits_left - 1'b1;
                        if (bit_idx == '0) begin
                            bit_idx <= '1;
                            tx_word <= tx_empty ? '0 : tx_rdata;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                end
                ST_HIGH: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        sclk_q  <= 1'b0;
                        if (bits_left == '0) begin
                            st <= ST_DONE;
                        end else if (bit_idx == '0) begin
                            bit_idx <= '1;
                            st      <= ST_LOAD;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            st      <= ST_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    cs_q <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign spi_sclk_o = sclk_q;
    assign spi_cs_n_o = cs_q;
    assign spi_dout   = tx_word[bit_idx];
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);
endmodule

// File: rtl/spi_burst_engine_chk.sv
`timescale 1ns/1ps
// Protocol checker for spi_burst_engine, attached by bind.
// Assumes: cfg_master only changes while the engine is idle.
module spi_burst_engine_chk
    import spi_burst_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cfg_master,
    input logic      busy,
    input logic      done,
    input logic      spi_sclk_o,
    input logic      spi_cs_n_o,
    input burst_st_e st,
    input logic      tx_empty
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n_o && !spi_sclk_o)); // R3
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && busy) |-> !spi_cs_n_o); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && st == ST_LOAD && tx_empty) |=> (st == ST_LOAD && !spi_sclk_o && !spi_cs_n_o)); // R4
    AST_SCLK_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk_o) |-> (busy && cfg_master)); // R1
endmodule

bind spi_burst_engine spi_burst_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .busy(busy), .done(done),
    .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o), .st(st), .tx_empty(tx_empty)
);

// File: tb/spi_burst_engine_test.sv
`timescale 1ns/1ps
// Directed bench for spi_burst_engine: one task per scenario.
module spi_burst_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic [11:0] cfg_len = '0;
    logic        cfg_ss_end = 1'b0;
    logic        start = 1'b0;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_full;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_data;
    logic        rx_empty, busy, done, spi_sclk_o, spi_cs_n_o, spi_dout;
    logic        sl_sclk = 1'b0, sl_cs_n = 1'b1, sl_din = 1'b0;
    logic        spi_din;

    int total = 0;
    int bad   = 0;

    logic cap  [0:255];
    logic expb [0:255];
    logic sbits[0:63];
    logic mcap [0:63];
    logic [31:0] tw [0:3];
    int ncap = 0, ndone = 0, ncsf = 0, nexp = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always #10 clk = ~clk;

    assign spi_din = cfg_master ? spi_dout : sl_din;

    spi_burst_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_len(cfg_len),
        .cfg_ss_end(cfg_ss_end), .start(start), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
        .busy(busy), .done(done), .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o),
        .spi_sclk_i(sl_sclk), .spi_cs_n_i(sl_cs_n), .spi_dout(spi_dout), .spi_din(spi_din)
    );

    // Line monitor: master bit capture, select falls and done pulses.
    always @(negedge clk) begin
        if (spi_sclk_o && !prev_sclk && ncap < 256) begin
            cap[ncap] = spi_dout;
            ncap++;
        end
        if (!spi_cs_n_o && prev_cs) ncsf++;
        if (done) ndone++;
        prev_sclk = spi_sclk_o;
        prev_cs   = spi_cs_n_o;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_data = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk({tag, " rx not empty"}, 32'(rx_empty), 32'd0);
        chk(tag, rx_data, exp);
        rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic clear_mon();
        ncap = 0; ndone = 0; ncsf = 0;
    endtask

    // Expected line stream from the framing rule of R2.
    task automatic build_exp(input int len);
        int k = 0;
        int w = 1;
        nexp = len + 1;
        for (int b = len % 32; b >= 0; b--) begin expb[k] = tw[0][b]; k++; end
        while (k < nexp) begin
            for (int b = 31; b >= 0; b--) if (k < nexp) begin expb[k] = tw[w][b]; k++; end
            w++;
        end
    endtask

    // Expected receive words from the packing rule of R5.
    task automatic check_rx_stream(input string tag, input int n);
        for (int i = 0; i < n; i += 32) begin
            logic [31:0] word = '0;
            for (int j = i; j < n && j < i + 32; j++) word = {word[30:0], expb[j]};
            pop_chk(tag, word);
        end
        @(negedge clk);
        chk({tag, " rx drained"}, 32'(rx_empty), 32'd1);
    endtask

    task automatic check_stream(input string tag);
        int mism = 0;
        chk({tag, " bit count"}, 32'(ncap), 32'(nexp));
        for (int i = 0; i < nexp; i++) if (cap[i] !== expb[i]) mism++;
        chk({tag, " line bits"}, 32'(mism), 32'd0);
    endtask

    task automatic wait_done();
        while (ndone == 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic master_go(input int len);
        cfg_master = 1'b1; cfg_len = 12'(len);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic test_reset();
        chk("R10 cs idle", 32'(spi_cs_n_o), 32'd1);
        chk("R10 sclk idle", 32'(spi_sclk_o), 32'd0);
        chk("R10 done low", 32'(done), 32'd0);
        chk("R10 busy low", 32'(busy), 32'd0);
        chk("R10 rx empty", 32'(rx_empty), 32'd1);
        chk("R10 tx not full", 32'(tx_full), 32'd0);
    endtask

    task automatic test_master_33();
        clear_mon();
        tw[0] = 32'h0000_0001; tw[1] = 32'hAAAA_AAAA;
        push(tw[0]); push(tw[1]);
        master_go(32);
        wait_done();
        build_exp(32);
        check_stream("R1 R2 33-bit");
        chk("R3 one select", 32'(ncsf), 32'd1);
        chk("R8 one done", 32'(ndone), 32'd1);
        chk("R8 idle after", 32'(busy), 32'd0);
        pop_chk("R5 33-bit word0", 32'hD555_5555);
        pop_chk("R5 33-bit word1", 32'h0000_0000);
    endtask

    task automatic test_master_8();
        clear_mon();
        tw[0] = 32'hFFFF_FFA5;
        push(tw[0]);
        master_go(7);
        wait_done();
        build_exp(7);
        check_stream("R2 8-bit");
        check_rx_stream("R5 8-bit", 8);
    endtask

    task automatic test_master_stall();
        clear_mon();
        tw[0] = 32'h0000_002D; tw[1] = 32'h1234_5678; tw[2] = 32'h9ABC_DEF0;
        push(tw[0]);
        master_go(69);
        repeat (300) @(negedge clk);
        chk("R4 bits before stall", 32'(ncap), 32'd6);
        chk("R4 sclk low in stall", 32'(spi_sclk_o), 32'd0);
        chk("R4 cs held in stall", 32'(spi_cs_n_o), 32'd0);
        chk("R4 busy in stall", 32'(busy), 32'd1);
        push(tw[1]); push(tw[2]);
        wait_done();
        build_exp(69);
        check_stream("R4 R2 70-bit");
        chk("R3 one select 70-bit", 32'(ncsf), 32'd1);
        check_rx_stream("R5 70-bit", 70);
    endtask

    task automatic drive_slave(input int n);
        sl_cs_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sl_din = sbits[i];
            repeat (8) @(negedge clk);
            mcap[i] = spi_dout;
            sl_sclk = 1'b1;
            repeat (8) @(negedge clk);
            sl_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        sl_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic test_slave_count();
        logic [11:0] pat = 12'hB7C;
        logic [7:0] seen = '0;
        clear_mon();
        cfg_master = 1'b0; cfg_ss_end = 1'b0; cfg_len = 12'd7;
        push(32'h0000_00C3);
        for (int i = 0; i < 12; i++) sbits[i] = pat[11-i];
        drive_slave(12);
        for (int i = 0; i < 8; i++) seen = {seen[6:0], mcap[i]};
        chk("R9 slave out framing", 32'(seen), 32'h0000_00C3);
        chk("R6 one done", 32'(ndone), 32'd1);
        pop_chk("R6 count-ended word", 32'h0000_00B7);
        @(negedge clk);
        chk("R6 extra edges ignored", 32'(rx_empty), 32'd1);
    endtask

    task automatic test_slave_select();
        logic [39:0] pat = 40'hDE_ADBE_EF5A;
        int ones = 0;
        clear_mon();
        cfg_master = 1'b0; cfg_ss_end = 1'b1; cfg_len = 12'd7;
        for (int i = 0; i < 40; i++) sbits[i] = pat[39-i];
        drive_slave(40);
        for (int i = 0; i < 40; i++) if (mcap[i] === 1'b1) ones++;
        chk("R9 zeros when tx empty", 32'(ones), 32'd0);
        chk("R7 one done", 32'(ndone), 32'd1);
        pop_chk("R7 word0", 32'hDEAD_BEEF);
        pop_chk("R7 R5 partial right-aligned", 32'h0000_005A);
        @(negedge clk);
        chk("R7 rx drained", 32'(rx_empty), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_master_33();
        test_master_8();
        test_master_stall();
        test_slave_count();
        test_slave_select();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule